// File: doc/BRIEF.md
# Variable-Length Operand Byte Decoder

This block follows a byte-wide instruction fetch stream in a stack-machine core. After the core has decoded a one-byte opcode, it asks this block for each parameter that follows, one request at a time, by giving a parameter-type code. The block takes one or two bytes from a valid/ready byte stream and returns a 16-bit parameter value with a valid strobe and the number of bytes it consumed. An opcode may carry from zero up to four parameters. The core issues one request for each.

Five parameter forms are handled. Three are single-byte forms: zero-extended, sign-extended, and a byte known to lie in 0..127. The fourth is a compact form whose length depends on the top bit of its first byte, with the upper half arriving first. The last is a two-byte word whose low half arrives first. The block holds its state through gaps in the byte stream. It keeps a finished value on its output until the consumer takes it, and only then accepts the next request.

Top module: `operand_byte_decoder`

## Requirements
- R1: Type code 0 (unsigned byte) consumes one byte. The result is that byte in bits 7:0, with bits 15:8 zero, and the count is 1.
- R2: Type code 1 (signed byte) consumes one byte. The result is that byte in bits 7:0, with bits 15:8 all equal to bit 7 of the byte, and the count is 1.
- R3: Type code 2 (small byte, values 0..127) consumes one byte and zero-extends it, so the count is 1.
- R4: Type code 3 (compact): if bit 7 of the first byte is 0, only that byte is consumed. The result equals the byte and the count is 1.
- R5: Type code 3 (compact): if bit 7 of the first byte is 1, a second byte is consumed. The result is {first byte with bit 7 cleared, second byte}, so bit 15 is always 0, and the count is 2.
- R6: Type code 4 (word) consumes two bytes. The first byte is bits 7:0, the second byte is bits 15:8, and the count is 2.
- R7: `in_ready` is high only while a byte of an accepted request is awaited. Bytes offered at any other time are not consumed. While `in_valid` is low between the first and second byte, the block waits without losing the first byte.
- R8: Every result reports a count of 1 or 2.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_count` stay unchanged and `res_valid` stays high.
- R10: `req_ready` is high only when no request is in progress and no result is pending. A new request can be accepted in the cycle after the result handshake.
- R11: Type codes 5, 6 and 7 behave as type code 0.
- R12: After reset, `req_ready` is 1, and `in_ready` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Parameter request offered |
| req_type | input | 3 | Parameter-type code (0..4, see requirements) |
| req_ready | output | 1 | Block can accept a request |
| in_valid | input | 1 | Byte stream: byte offered |
| in_byte | input | 8 | Byte stream: data |
| in_ready | output | 1 | Byte stream: byte taken at this edge when valid |
| res_valid | output | 1 | Parameter value available |
| res_data | output | 16 | Assembled parameter value |
| res_count | output | 2 | Bytes consumed for this value |
| res_ready | input | 1 | Consumer takes the value |

## Verification
The bench aims at the compact form's length switch. It sends values just below and just above 0x80, plus 0xFF 0xFF. A design that tested the wrong bit, or forgot to clear bit 7, would give the wrong count or a value with bit 15 set. It sends a word with distinct low and high bytes to expose swapped byte order, and a signed byte with bit 7 set and clear to expose a missing or constant extension. It also leaves gaps between the two bytes, offers bytes while idle, and holds the result back. A design that dropped the first byte, consumed unsolicited bytes, let the output drift or took a second request too early would show it at the ports.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [TYPE_W-1:0] {
        PT_UBYTE = 3'd0,
        PT_SBYTE = 3'd1,
        PT_SMALL = 3'd2,
        PT_COMPACT = 3'd3,
        PT_WORD = 3'd4
    } ptype_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FIRST = 2'd1,
        PH_SECOND = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

endpackage

// File: rtl/opd_len.sv
// Decides whether a parameter needs a second byte.
module opd_len
    import opd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [TYPE_W-1:0] ptype,
    input  logic [BYTE_W-1:0] first_byte,
    output logic              two_bytes
);
    always_comb begin
        case (ptype)
            PT_COMPACT: two_bytes = first_byte[BYTE_W-1];
            PT_WORD:    two_bytes = 1'b1;
            default:    two_bytes = 1'b0;
        endcase
    end
endmodule

// File: rtl/opd_merge.sv
// Forms the parameter value from one or two bytes.
module opd_merge
    import opd_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic [TYPE_W-1:0] ptype,
    input  logic [BYTE_W-1:0] lead,
    input  logic [BYTE_W-1:0] trail,
    input  logic              pair,
    output logic [VAL_W-1:0]  value
);
    always_comb begin
        case (ptype)
            PT_SBYTE:   value = {{BYTE_W{lead[BYTE_W-1]}}, lead};
            PT_COMPACT: value = pair ? {1'b0, lead[BYTE_W-2:0], trail}
                                     : {{BYTE_W{1'b0}}, lead};
            PT_WORD:    value = {trail, lead};
            default:    value = {{BYTE_W{1'b0}}, lead};
        endcase
    end
endmodule

// File: rtl/operand_byte_decoder.sv
module operand_byte_decoder
    import opd_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TYPE_W-1:0] req_type,
    output logic              req_ready,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              res_valid,
    output logic [VAL_W-1:0]  res_data,
    output logic [1:0]        res_count,
    input  logic              res_ready
);

    typedef struct packed {
        phase_e            phase;
        logic [TYPE_W-1:0] ptype;
        logic [BYTE_W-1:0] lead;
        logic [VAL_W-1:0]  value;
        logic [1:0]        count;
    } state_t;

    state_t st_d, st_q;

    logic              need_two;
    logic [BYTE_W-1:0] lead_src;
    logic              pair_sel;
    logic [VAL_W-1:0]  merged;

    assign lead_src = (st_q.phase == PH_FIRST) ? in_byte : st_q.lead;
    assign pair_sel = (st_q.phase == PH_SECOND);

    opd_len #(.BYTE_W(BYTE_W)) u_len (
        .ptype      (st_q.ptype),
        .first_byte (in_byte),
        .two_bytes  (need_two)
    );

    opd_merge #(.BYTE_W(BYTE_W)) u_merge (
        .ptype (st_q.ptype),
        .lead  (lead_src),
        .trail (in_byte),
        .pair  (pair_sel),
        .value (merged)
    );

    assign req_ready = (st_q.phase == PH_IDLE);
    assign in_ready  = (st_q.phase == PH_FIRST) || (st_q.phase == PH_SECOND);
    assign res_valid = (st_q.phase == PH_HOLD);
    assign res_data  = st_q.value;
    assign res_count = st_q.count;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ptype = req_type;
                    st_d.phase = PH_FIRST;
                end
            end
            PH_FIRST: begin
                if (in_valid) begin
                    st_d.lead = in_byte;
                    if (need_two) begin
                        st_d.phase = PH_SECOND;
                    end else begin
                        st_d.value = merged;
                        st_d.count = 2'd1;
                        st_d.phase = PH_HOLD;
                    end
                end
            end
            PH_SECOND: begin
                if (in_valid) begin
                    st_d.value = merged;
                    st_d.count = 2'd2;
                    st_d.phase = PH_HOLD;
                end
            end
            default: begin
                if (res_ready) begin
                    st_d.phase = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ptype: '0, lead: '0, value: '0, count: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_UB_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_UBYTE |-> res_data[VAL_W-1:BYTE_W] == '0 && res_count == 2'd1); // R1
    AST_SB_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_SBYTE |-> res_data[VAL_W-1:BYTE_W] == {BYTE_W{res_data[BYTE_W-1]}}); // R2
    AST_SMALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_SMALL |-> res_count == 2'd1 && res_data[VAL_W-1:BYTE_W] == '0); // R3
    AST_COMPACT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_COMPACT && res_count == 2'd1 |-> res_data[VAL_W-1:BYTE_W-1] == '0); // R4
    AST_COMPACT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_COMPACT |-> !res_data[VAL_W-1]); // R5
    AST_WORD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype == PT_WORD |-> res_count == 2'd2); // R6
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_SECOND && !in_valid |=> st_q.phase == PH_SECOND && $stable(st_q.lead)); // R7
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_count == 2'd1 || res_count == 2'd2); // R8
    AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_count)); // R9
    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !res_valid && !in_ready); // R10
    AST_SPARE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && st_q.ptype > PT_WORD |-> res_count == 2'd1 && res_data[VAL_W-1:BYTE_W] == '0); // R11

endmodule

// File: tb/tb_operand_byte_decoder.sv
`timescale 1ns/1ps
module tb_operand_byte_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = '0;
    logic        req_ready;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        res_valid;
    logic [15:0] res_data;
    logic [1:0]  res_count;
    logic        res_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    operand_byte_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_ready(req_ready),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .res_valid(res_valid), .res_data(res_data), .res_count(res_count),
        .res_ready(res_ready)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_req(logic [2:0] t);
        req_valid = 1'b1;
        req_type = t;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        in_byte = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic take_result(string tag, int expv, int expc);
        chk({tag, " valid"}, res_valid, 1);
        chk({tag, " data"}, res_data, expv);
        chk({tag, " count"}, res_count, expc);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk({tag, " R10 idle after take"}, req_ready, 1);
    endtask

    task automatic one_param(string tag, logic [2:0] t, logic [7:0] b0,
                             logic [7:0] b1, bit two, int expv, int expc);
        send_req(t);
        send_byte(b0);
        if (two) send_byte(b1);
        take_result(tag, expv, expc);
    endtask

    task automatic t_reset;
        chk("R12 req_ready", req_ready, 1);
        chk("R12 in_ready", in_ready, 0);
        chk("R12 res_valid", res_valid, 0);
    endtask

    task automatic t_single_bytes;
        one_param("R1 ubyte", 3'd0, 8'hA5, 8'h00, 0, 16'h00A5, 1);
        one_param("R2 sbyte neg", 3'd1, 8'hA5, 8'h00, 0, 16'hFFA5, 1);
        one_param("R2 sbyte pos", 3'd1, 8'h35, 8'h00, 0, 16'h0035, 1);
        one_param("R3 small", 3'd2, 8'h7F, 8'h00, 0, 16'h007F, 1);
        one_param("R11 code6", 3'd6, 8'h9C, 8'h00, 0, 16'h009C, 1);
        one_param("R11 code7", 3'd7, 8'hF0, 8'h00, 0, 16'h00F0, 1);
    endtask

    task automatic t_compact;
        one_param("R4 compact short", 3'd3, 8'h45, 8'h00, 0, 16'h0045, 1);
        one_param("R4 compact 7F", 3'd3, 8'h7F, 8'h00, 0, 16'h007F, 1);
        one_param("R5 compact long", 3'd3, 8'h81, 8'h02, 1, 16'h0102, 2);
        one_param("R5 compact max", 3'd3, 8'hFF, 8'hFF, 1, 16'h7FFF, 2);
        one_param("R5 compact 80 80", 3'd3, 8'h80, 8'h80, 1, 16'h0080, 2);
    endtask

    task automatic t_word_gap;
        send_req(3'd4);
        send_byte(8'h34);
        for (int i = 0; i < 3; i++) begin
            in_byte = 8'h99;
            @(negedge clk);
        end
        chk("R7 gap no result", res_valid, 0);
        chk("R7 gap still ready", in_ready, 1);
        send_byte(8'h12);
        take_result("R6 word", 16'h1234, 2);
        one_param("R6 word swap", 3'd4, 8'h12, 8'h34, 1, 16'h3412, 2);
    endtask

    task automatic t_idle_bytes;
        in_byte = 8'hEE;
        in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 idle not ready", in_ready, 0);
        end
        in_valid = 1'b0;
        one_param("R7 idle bytes ignored", 3'd0, 8'h12, 8'h00, 0, 16'h0012, 1);
    endtask

    task automatic t_backpressure;
        send_req(3'd4);
        send_byte(8'hCD);
        send_byte(8'hAB);
        req_valid = 1'b1;
        req_type = 3'd0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 held valid", res_valid, 1);
            chk("R9 held data", res_data, 16'hABCD);
            chk("R10 no req while pending", req_ready, 0);
            chk("R10 no byte while pending", in_ready, 0);
        end
        req_valid = 1'b0;
        take_result("R9 after hold", 16'hABCD, 2);
        one_param("R10 next request", 3'd1, 8'h80, 8'h00, 0, 16'hFF80, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bytes();
        t_compact();
        t_word_gap();
        t_idle_bytes();
        t_backpressure();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule